// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects three interrupt sources for a small sequencer-driven processor. The sources are a general-purpose timer overflow, a display-refresh timer overflow and a keypad press. Each source has its own pending latch. A hardware event pulse or a manual pushbutton input can set that latch. When interrupts are enabled and no service routine is running, the controller raises a request line. It also presents the number and vector address of the most urgent pending source.

The sequencer asserts an instruction-boundary strobe between instructions. When that strobe arrives while a request is up, the controller answers in the same cycle with a take acknowledgment. The sequencer treats that acknowledgment as the signal to save its context. At the same clock edge, the controller clears the winning latch and marks a service routine as active. Further interrupts are then held off until the sequencer pulses resume, which signals that the context has been restored. Saving and restoring the context is left to the sequencer.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, no source is pending, `in_service` is 0, and `irq_req`, `take_ack` and `vec_idx` are all 0.
- R2: A one-cycle high on a source's hardware pulse input or on its manual set bit makes that source pending from the next clock edge. The source stays pending until it is taken. Manual bit 0 belongs to the general timer, bit 1 to the display timer and bit 2 to the keypad.
- R3: `irq_req` is high exactly when at least one source is pending, `int_enable` is high and `in_service` is low.
- R4: Priority is fixed: general timer, then display timer, then keypad. While a source is pending, `vec_idx` shows the winner's interrupt number: 1 for the general timer, 3 for the display timer, 4 for the keypad. It shows 0 when nothing is pending.
- R5: `vec_addr` equals `VEC_BASE + VEC_STRIDE * vec_idx`. With the defaults (base 0x800, stride 4), the addresses are 0x804, 0x80C and 0x810.
- R6: `take_ack` is high in a cycle exactly when `insn_bound` and `irq_req` are both high in that cycle.
- R7: At the edge that ends a take cycle, only the winner's pending latch is cleared, and `in_service` becomes 1. Sources that lose, and sources set in that cycle, remain pending.
- R8: While `in_service` is 1, no take happens. A `resume` pulse clears `in_service` at the next edge. A `resume` pulse while `in_service` is 0 has no effect.
- R9: Requests are merged, not counted. Repeated events on an already pending source, or an event on a source in the same cycle that source is taken, still result in exactly one take.
- R10: While `int_enable` is low, events are still latched, but `irq_req` and `take_ack` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_gen_ovf | input | 1 | General-purpose timer overflow pulse |
| tmr_disp_ovf | input | 1 | Display-refresh timer overflow pulse |
| key_press | input | 1 | Keypad press pulse |
| man_set | input | 3 | Manual pushbutton set bits (0 general, 1 display, 2 keypad) |
| insn_bound | input | 1 | Instruction-boundary strobe from the sequencer |
| int_enable | input | 1 | Interrupt enable flag |
| resume | input | 1 | Context restored, service routine finished |
| irq_req | output | 1 | Interrupt request toward the sequencer |
| vec_idx | output | 3 | Interrupt number of the winning source |
| vec_addr | output | ADDR_W | Vector address of the winning source |
| take_ack | output | 1 | Interrupt taken this cycle; save context |
| in_service | output | 1 | A service routine is active |

## Verification
The two functions that can fall in the same clock edge are clearing a latch because it was taken and setting a latch because a new event arrived. The bench provokes this collision by pulsing a source's event in the very cycle the strobe takes that source. In a separate case, it pulses a lower-priority source during a take. After resume, the first case must leave no request (the new event was merged into the take). The second case must leave the lower source pending with its own vector. All non-empty combinations of pending sources are swept through both the hardware and the manual paths, and the bench computes the take order and addresses arithmetically.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   localparam int unsigned SRC_N = 3;
   localparam int unsigned NUM_W = 3;

   typedef logic [NUM_W-1:0] irq_num_t;

   // Interrupt number carried by each source slot; slot 0 has top priority.
   function automatic irq_num_t src_number(input int unsigned slot);
      case (slot)
         0:       return irq_num_t'(1);
         1:       return irq_num_t'(3);
         default: return irq_num_t'(4);
      endcase
   endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_hw,
   input  logic set_man,
   input  logic clr,
   output logic pend
);

   logic pend_q;

   // Clear wins over a same-cycle set: that event is merged into the take.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (clr)
         pend_q <= 1'b0;
      else if (set_hw || set_man)
         pend_q <= 1'b1;
   end

   assign pend = pend_q;

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
   import irq_vec_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned VEC_BASE   = 12'h800,
   parameter int unsigned VEC_STRIDE = 4
) (
   input  logic [SRC_N-1:0]  pend,
   output logic              any,
   output logic [SRC_N-1:0]  win,
   output irq_num_t          num,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(VEC_BASE);
   localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(VEC_STRIDE);

   // Walk from lowest to highest priority so the top slot overrides.
   always_comb begin
      win = '0;
      num = '0;
      for (int i = SRC_N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            win    = '0;
            win[i] = 1'b1;
            num    = src_number(i);
         end
      end
   end

   assign any  = |pend;
   assign addr = BASE_V + STRIDE_V * ADDR_W'(num);

endmodule

// File: rtl/irq_take_ctl.sv
module irq_take_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic any_pend,
   input  logic int_enable,
   input  logic insn_bound,
   input  logic resume,
   output logic req,
   output logic take,
   output logic busy
);

   logic busy_q;

   assign req  = any_pend && int_enable && !busy_q;
   assign take = req && insn_bound;

   // A take cannot coincide with resume, since a take needs busy_q low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_q <= 1'b0;
      else if (take)
         busy_q <= 1'b1;
      else if (resume)
         busy_q <= 1'b0;
   end

   assign busy = busy_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vec_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned VEC_BASE   = 12'h800,
   parameter int unsigned VEC_STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_gen_ovf,
   input  logic              tmr_disp_ovf,
   input  logic              key_press,
   input  logic [2:0]        man_set,
   input  logic              insn_bound,
   input  logic              int_enable,
   input  logic              resume,
   output logic              irq_req,
   output logic [2:0]        vec_idx,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              take_ack,
   output logic              in_service
);

   localparam longint unsigned TOP_ADDR = longint'(VEC_BASE) + longint'(VEC_STRIDE) * 4;

   if (ADDR_W < 4 || ADDR_W > 31) begin : g_bad_width
      $error("irq_vector_ctrl: ADDR_W must lie in 4..31");
   end
   if (VEC_STRIDE == 0) begin : g_bad_stride
      $error("irq_vector_ctrl: VEC_STRIDE must be nonzero");
   end
   if (TOP_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_base
      $error("irq_vector_ctrl: vector table does not fit in ADDR_W bits");
   end

   logic [SRC_N-1:0] hw_evt;
   logic [SRC_N-1:0] pend;
   logic [SRC_N-1:0] win;
   logic             any_pend;
   logic             take;
   irq_num_t         num;

   assign hw_evt = {key_press, tmr_disp_ovf, tmr_gen_ovf};

   for (genvar g = 0; g < SRC_N; g++) begin : g_src
      irq_pend_latch u_latch (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_hw  (hw_evt[g]),
         .set_man (man_set[g]),
         .clr     (take && win[g]),
         .pend    (pend[g])
      );
   end

   irq_prio_sel #(
      .ADDR_W     (ADDR_W),
      .VEC_BASE   (VEC_BASE),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_sel (
      .pend (pend),
      .any  (any_pend),
      .win  (win),
      .num  (num),
      .addr (vec_addr)
   );

   irq_take_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_pend   (any_pend),
      .int_enable (int_enable),
      .insn_bound (insn_bound),
      .resume     (resume),
      .req        (irq_req),
      .take       (take),
      .busy       (in_service)
   );

   assign vec_idx  = num;
   assign take_ack = take;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned VEC_BASE   = 12'h800,
   parameter int unsigned VEC_STRIDE = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_bound,
   input logic              int_enable,
   input logic              resume,
   input logic              irq_req,
   input logic [2:0]        vec_idx,
   input logic [ADDR_W-1:0] vec_addr,
   input logic              take_ack,
   input logic              in_service
);

   p_ack_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_ack |-> (insn_bound && irq_req));

   p_ack_opens_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_ack |=> in_service);

   p_service_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_service && !resume) |=> in_service);

   p_resume_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_service && resume) |=> !in_service);

   p_no_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_service |-> (!take_ack && !irq_req));

   p_legal_number_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (vec_idx == 3'd1 || vec_idx == 3'd3 || vec_idx == 3'd4));

   p_addr_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (vec_addr == ADDR_W'(VEC_BASE + VEC_STRIDE * vec_idx)));

   p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !int_enable |-> (!irq_req && !take_ack));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STRIDE (VEC_STRIDE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_bound (insn_bound),
   .int_enable (int_enable),
   .resume     (resume),
   .irq_req    (irq_req),
   .vec_idx    (vec_idx),
   .vec_addr   (vec_addr),
   .take_ack   (take_ack),
   .in_service (in_service)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

   localparam int CLK_P = 10;
   localparam int AW    = 12;
   localparam int BASE  = 12'h800;
   localparam int STEP  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tmr_gen_ovf = 1'b0, tmr_disp_ovf = 1'b0, key_press = 1'b0;
   logic [2:0]    man_set = '0;
   logic          insn_bound = 1'b0, int_enable = 1'b0, resume = 1'b0;
   logic          irq_req, take_ack, in_service;
   logic [2:0]    vec_idx;
   logic [AW-1:0] vec_addr;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P / 2) clk = ~clk;

   irq_vector_ctrl #(.ADDR_W(AW), .VEC_BASE(BASE), .VEC_STRIDE(STEP)) uut (
      .clk(clk), .rst_n(rst_n), .tmr_gen_ovf(tmr_gen_ovf), .tmr_disp_ovf(tmr_disp_ovf),
      .key_press(key_press), .man_set(man_set), .insn_bound(insn_bound),
      .int_enable(int_enable), .resume(resume), .irq_req(irq_req), .vec_idx(vec_idx),
      .vec_addr(vec_addr), .take_ack(take_ack), .in_service(in_service)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int num_of(input int slot);
      return (slot == 0) ? 1 : (slot == 1) ? 3 : 4;
   endfunction

   function automatic int top_num(input logic [2:0] m);
      for (int s = 0; s < 3; s++) if (m[s]) return num_of(s);
      return 0;
   endfunction

   // One-cycle event on a slot, through the hardware or the manual path.
   task automatic pulse(input int slot, input bit manual);
      if (manual) man_set[slot] = 1'b1;
      else if (slot == 0) tmr_gen_ovf = 1'b1;
      else if (slot == 1) tmr_disp_ovf = 1'b1;
      else key_press = 1'b1;
      @(negedge clk);
      man_set = '0; tmr_gen_ovf = 1'b0; tmr_disp_ovf = 1'b0; key_press = 1'b0;
   endtask

   task automatic check_vec(input string tag, input logic [2:0] m);
      chk({tag, " R4 vec_idx"}, vec_idx, top_num(m));
      if (m != 0) chk({tag, " R5 vec_addr"}, vec_addr, BASE + STEP * top_num(m));
   endtask

   // Take the current winner, confirm nesting is blocked, then resume.
   task automatic take_and_resume(input string tag);
      insn_bound = 1'b1;
      #1 chk({tag, " R6 take_ack"}, take_ack, 1);
      @(negedge clk);
      chk({tag, " R7 in_service"}, in_service, 1);
      chk({tag, " R8 req blocked"}, irq_req, 0);
      #1 chk({tag, " R8 no nested take"}, take_ack, 0);
      @(negedge clk);
      insn_bound = 1'b0;
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
      chk({tag, " R8 resume clears"}, in_service, 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [2:0] m;
      repeat (3) @(negedge clk);
      chk("R1 irq_req", irq_req, 0);
      chk("R1 in_service", in_service, 0);
      chk("R1 take_ack", take_ack, 0);
      chk("R1 vec_idx", vec_idx, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Idle boundary strobe and idle resume change nothing.
      int_enable = 1'b1;
      insn_bound = 1'b1;
      #1 chk("R6 no take when empty", take_ack, 0);
      @(negedge clk);
      insn_bound = 1'b0;
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
      chk("R8 idle resume ignored", in_service, 0);
      chk("R3 empty no req", irq_req, 0);

      // Sweep every non-empty pending set, alternating entry paths.
      for (int mask = 1; mask < 8; mask++) begin
         int_enable = 1'b0;
         for (int s = 0; s < 3; s++)
            if (mask[s]) begin
               pulse(s, ((mask + s) % 2) == 1);
               pulse(s, ((mask + s) % 2) == 0);  // R9 duplicate merges
            end
         chk("R10 masked no req", irq_req, 0);
         insn_bound = 1'b1;
         #1 chk("R10 masked no take", take_ack, 0);
         @(negedge clk);
         insn_bound = 1'b0;
         int_enable = 1'b1;
         #1;
         m = mask[2:0];
         chk("R2 R3 req after latch", irq_req, 1);
         while (m != 0) begin
            check_vec("sweep", m);
            take_and_resume("sweep");
            for (int s = 0; s < 3; s++)
               if (m[s]) begin m[s] = 1'b0; break; end
            chk("R9 R3 req after resume", irq_req, (m != 0) ? 1 : 0);
         end
         check_vec("sweep empty", m);
      end

      // Collision: same source fires during its own take.
      pulse(0, 1'b0);
      insn_bound = 1'b1;
      tmr_gen_ovf = 1'b1;
      #1 chk("R6 collide take", take_ack, 1);
      @(negedge clk);
      insn_bound = 1'b0; tmr_gen_ovf = 1'b0;
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
      chk("R9 same-cycle event merged", irq_req, 0);

      // Collision: lower source fires during a take of a higher one.
      pulse(0, 1'b1);
      insn_bound = 1'b1;
      key_press = 1'b1;
      @(negedge clk);
      insn_bound = 1'b0; key_press = 1'b0;
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
      chk("R7 other source kept", irq_req, 1);
      check_vec("R7 collide", 3'b100);
      take_and_resume("collide");
      chk("R7 drained", irq_req, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule